// File: doc/BRIEF.md
# Sklansky Parallel Prefix Adder

This block is a purely combinational binary adder. It adds two N-bit operands and a carry-in, and it returns an N-bit sum and a carry-out. Every bit position first produces a generate term (a AND b) and a propagate term (a XOR b). The carry-in enters the network as an extra lowest position, with generate equal to the carry-in and propagate forced to 0.

A recursive divide-and-conquer prefix network then merges the (generate, propagate) pairs. Each stage splits its span into a lower half of floor(n/2) positions and an upper half that holds the rest. It solves each half on its own, then combines every upper-half result with the highest result of the lower half. The merge operator is (gL,pL)∘(gH,pH) = (gH | pH&gL, pH&pL), with the lower-index group always on the left. The group generate of positions 0..i is the carry into bit i. Each sum bit is its propagate XORed with that carry.

The network is written once as a self-instantiating module, so any positive width elaborates. The logic depth is ceil(log2(N+1)) operator levels. The adder suits paths where carry depth sets timing, and it carries no registers.

Top module: `sklansky_adder`

## Requirements
- R1: For every input, {cout, sum} equals the arithmetic value a + b + cin, taken modulo 2^(N+1).
- R2: Where a bit has exactly one operand bit set (propagate), the carry out of that bit equals the carry into it. With a = all ones, b = 0 and cin = 1, the result is sum = 0 and cout = 1.
- R3: The carry into bit 0 is cin, and the network's group propagate is 0 at every position. With a = b = 0, sum equals cin in bit 0 and cout is 0.
- R4: A bit with both operand bits clear (kill) forces the carry out of that bit to 0. With a = 0x7FFF, b = 0 and cin = 1, the result is sum = 0x8000 and cout = 0.
- R5: A bit with both operand bits set (generate) forces the carry out of that bit to 1. With a = b = 0x8000, the result is sum = 0 and cout = 1.
- R6: A width that is not a power of two (N = 5) gives a correct result for all 2048 combinations of a, b and cin.
- R7: The degenerate width N = 1 gives a correct result for all 8 input combinations.
- R8: The default width is 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Sum bits |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
The block holds no state. A wrong merge node therefore shows in the same evaluation as the input that reaches it, and it shows as a wrong carry into one or more sum bits. The usual causes are swapped operand order, a wrong lower-half tap, or a missed split for an odd span.

Such a fault appears only for operand patterns that route a generate across that node's span. For this reason the checks combine exhaustive sweeps at small odd widths with long propagate runs, kill barriers and random 16-bit vectors. A fault seen at the ports never lingers: it disappears as soon as the inputs change.

// File: rtl/sk_prefix_net.sv
module sk_prefix_net #(
  parameter int W = 2
) (
  input  logic [W-1:0] gi,
  input  logic [W-1:0] pi,
  output logic [W-1:0] go,
  output logic [W-1:0] po
);
  if (W == 1) begin : g_leaf
    assign go = gi;
    assign po = pi;
  end else begin : g_split
    localparam int K = W / 2;
    localparam int R = W - K;
    logic [K-1:0] lg, lp;
    logic [R-1:0] rg, rp;

    sk_prefix_net #(.W(K)) u_lo (.gi(gi[K-1:0]), .pi(pi[K-1:0]), .go(lg), .po(lp));
    sk_prefix_net #(.W(R)) u_hi (.gi(gi[W-1:K]), .pi(pi[W-1:K]), .go(rg), .po(rp));

    assign go[K-1:0] = lg;
    assign po[K-1:0] = lp;

    // lower group always on the left of the operator
    for (genvar j = 0; j < R; j++) begin : g_merge
      assign go[K+j] = rg[j] | (rp[j] & lg[K-1]);
      assign po[K+j] = rp[j] & lp[K-1];
    end
  end
endmodule

// File: rtl/sklansky_adder.sv
module sklansky_adder #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  localparam int M = N + 1;

  logic [M-1:0] gi, pi, go, po;

  assign gi = {a & b, cin};
  assign pi = {a ^ b, 1'b0};

  sk_prefix_net #(.W(M)) u_net (.gi(gi), .pi(pi), .go(go), .po(po));

  assign sum  = pi[M-1:1] ^ go[M-2:0];
  assign cout = go[M-1];

  always_comb begin
    AST_CIN_SEED: assert (go[0] == cin);                 // R3
    AST_NO_GROUP_PROP: assert (po == '0);                // R3
    AST_TOTAL: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin})); // R1
    for (int i = 0; i < N; i++) begin
      if (!a[i] && !b[i]) AST_KILL_STOP: assert (!go[i+1]);      // R4
      if (a[i] && b[i])   AST_GEN_SET: assert (go[i+1]);         // R5
      if (a[i] ^ b[i])    AST_PROP_PASS: assert (go[i+1] == go[i]); // R2
    end
  end
endmodule

// File: tb/sim_sklansky_adder.sv
module sim_sklansky_adder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] a16, b16, s16;
  logic        c16, co16;
  logic [4:0]  a5, b5, s5;
  logic        c5, co5;
  logic [0:0]  a1, b1, s1;
  logic        c1, co1;

  sklansky_adder u0 (.a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));
  sklansky_adder #(.N(5)) u1 (.a(a5), .b(b5), .cin(c5), .sum(s5), .cout(co5));
  sklansky_adder #(.N(1)) u2 (.a(a1), .b(b1), .cin(c1), .sum(s1), .cout(co1));

  // {a, b, cin, sum, cout}
  localparam logic [49:0] VEC [0:9] = '{
    {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},  // R3
    {16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0},  // R3
    {16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1},  // R2
    {16'h7FFF, 16'h0000, 1'b1, 16'h8000, 1'b0},  // R4
    {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1},  // R5
    {16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1},  // R1
    {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0},  // R1
    {16'h00FF, 16'h0001, 1'b0, 16'h0100, 1'b0},  // R1
    {16'hA5A5, 16'h5A5A, 1'b0, 16'hFFFF, 1'b0},  // R2
    {16'hFFFE, 16'h0001, 1'b1, 16'h0000, 1'b1}   // R2
  };
  localparam string TAG [0:9] = '{"R3", "R3", "R2", "R4", "R5", "R1", "R1", "R1", "R2", "R2"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    logic [16:0] ref17;
    a16 = '0; b16 = '0; c16 = 1'b0;
    a5 = '0; b5 = '0; c5 = 1'b0;
    a1 = '0; b1 = '0; c1 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 reset", {15'd0, co16, s16}, 32'd0);
    rst = 1'b0;

    for (int k = 0; k < 10; k++) begin
      @(posedge clk);
      {a16, b16, c16} = VEC[k][49:17];
      @(negedge clk);
      chk(TAG[k], {15'd0, co16, s16}, {15'd0, VEC[k][0], VEC[k][16:1]});
    end

    // R8: default width gives 16 sum bits; 0xFFFF+1 overflows only at bit 16
    @(posedge clk);
    a16 = 16'hFFFF; b16 = 16'h0001; c16 = 1'b0;
    @(negedge clk);
    chk("R8", {15'd0, co16, s16}, 32'h0001_0000);

    for (int k = 0; k < 300; k++) begin
      @(posedge clk);
      a16 = 16'($urandom); b16 = 16'($urandom); c16 = 1'($urandom);
      @(negedge clk);
      ref17 = {1'b0, a16} + {1'b0, b16} + {16'd0, c16};
      chk("R1 random", {15'd0, co16, s16}, {15'd0, ref17});
    end

    for (int x = 0; x < 2048; x++) begin
      @(posedge clk);
      {a5, b5, c5} = 11'(x);
      @(negedge clk);
      chk("R6", {26'd0, co5, s5}, 32'(a5) + 32'(b5) + 32'(c5));
    end

    for (int x = 0; x < 8; x++) begin
      @(posedge clk);
      {a1, b1, c1} = 3'(x);
      @(negedge clk);
      chk("R7", {30'd0, co1, s1}, 32'(a1) + 32'(b1) + 32'(c1));
    end

    finish_run();
  end
endmodule